// File: doc/BRIEF.md
# Oscillator Configuration Register Interface

This block holds the configuration registers of a programmable clock oscillator. It is driven by byte-level events from a two-wire bus target front end: start of a write transfer, start of a read transfer, end of transfer (finish or NACK), a received byte, and a request for a byte to send. The first byte after a write start is a device register address. The block translates it into an internal pointer over eight registers: six frequency registers (indices 0 to 5) and two control registers (index 6 for control A and index 7 for control B). Each later byte is written to the register under the pointer.

The translation depends on the stability grade of the oscillator, which is set by the `STAB_PPM` parameter (7, 20 or 50; the default is 50). The block checks the freeze bits on every write to a frequency register and pulses an error output when the write breaks the freeze rule. Control A carries a soft-reset bit and a new-frequency bit that clear themselves. A write to control A also drops the divider-freeze bit in control B.

Top module: `osc_cfg_regs`

## Requirements
- R1: `phase` encodes idle=0, addressing=1, address-done=2, writing=3, reading=4. A write start enters 1, a read start enters 4, and end-of-transfer enters 0. In the same cycle, end-of-transfer beats write start, write start beats read start, and any of these three beats a received byte, which is then dropped.
- R2: A received byte in phase 1 is an address and moves the phase to 2. Address 135 sets the pointer to 6 and address 137 sets it to 7. Any other address above 18 leaves the pointer unchanged.
- R3: An address of 18 or below sets the pointer to (address − 7) mod 256 for the 20 and 50 ppm grades, and to (address − 13) mod 256 for the 7 ppm grade.
- R4: A received byte in any phase other than 1 is data and moves the phase to 3. With the pointer at 0 to 5, the byte is stored and the pointer increments. With the pointer at 8 or above, the byte changes no register.
- R5: A data byte with the pointer at 6 or 7 is written to that control register, and the pointer does not move.
- R6: In the cycle after `rd_req`, `rd_byte` shows the register at the pointer, or 0x00 when the pointer is 8 or above. Reads never move the pointer.
- R7: After `rst_n` is low, indices 0 to 5 hold 0x40, 0xC2, 0xBC, 0x01, 0x1E, 0xB8, both control registers hold 0x00, the pointer is 0, the phase is 0, and `freeze_err` is 0.
- R8: A write to control A stores the byte with bits 7 (soft reset) and 6 (new frequency) forced to 0, and clears bit 4 of control B. If bit 7 of the written byte is 1, indices 0 to 5 also return to their R7 values.
- R9: A frequency write counts as a fraction update when the pointer is 2 to 5, or when the pointer is 1 and the stored index-1 value has a nonzero bits 5:0. A fraction update needs control A bit 5 or control B bit 4 set. Any other frequency write (a divider update) needs control B bit 4.
- R10: A frequency write that breaks R9 raises `freeze_err` for exactly one cycle, in the cycle after the byte, and the byte is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_wr_start | input | 1 | Start of a write transfer |
| ev_rd_start | input | 1 | Start of a read transfer |
| ev_stop | input | 1 | Finish or NACK; ends the transfer |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Request for the byte to send |
| rd_byte | output | 8 | Byte for the bus, valid in the cycle after `rd_req` |
| freeze_err | output | 1 | One-cycle pulse when a write breaks the freeze rule |
| phase | output | 3 | Transfer phase (encoding in R1) |

## Verification
The bench builds two copies of the block that share one stimulus: `u0` with the default 50 ppm grade and a second copy with the 7 ppm grade. Both address offsets are therefore covered in one run. Every address from 0 to 255 is sent to both copies. This exercises the two control addresses, the ignored high addresses and the pointer wrap below zero that sends small addresses out of the register range. All expected values come from arithmetic in the bench. The 50 ppm copy then goes through the freeze matrix, both index-1 classifications, soft reset and the writes that must be ignored.

// File: rtl/osc_cfg_pkg.sv
// Shared types and constants for the oscillator configuration registers.
// Assumes byte-wide registers and an eight-entry internal register space.
package osc_cfg_pkg;

    localparam int BYTE_W  = 8;
    localparam int NFREQ   = 6;
    localparam int NREGS   = NFREQ + 2;
    localparam int IDX_CA  = NFREQ;       // control A
    localparam int IDX_CB  = NFREQ + 1;   // control B
    localparam int CA_SRST = 7;
    localparam int CA_NEWF = 6;
    localparam int CA_FRZM = 5;
    localparam int CB_FRZD = 4;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_ADONE = 3'd2,
        PH_WRITE = 3'd3,
        PH_READ  = 3'd4
    } phase_e;

    // Power-up and soft-reset contents of the frequency registers.
    function automatic logic [BYTE_W-1:0] freq_rst_val(input int idx);
        case (idx)
            0:       return 8'h40;
            1:       return 8'hC2;
            2:       return 8'hBC;
            3:       return 8'h01;
            4:       return 8'h1E;
            default: return 8'hB8;
        endcase
    endfunction

endpackage

// File: rtl/osc_addr_map.sv
// Translates a device register address into the internal pointer.
// Assumes the caller loads the result only for an address byte.
module osc_addr_map
    import osc_cfg_pkg::*;
#(
    parameter int STAB_PPM = 50
) (
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] cur_ptr,
    output logic [BYTE_W-1:0] new_ptr
);

    localparam logic [BYTE_W-1:0] OFS     = (STAB_PPM == 7) ? 8'd13 : 8'd7;
    localparam logic [BYTE_W-1:0] LOW_MAX = 8'd18;

    // Pick the control index, hold the pointer, or subtract the grade offset.
    always_comb begin
        if (addr > LOW_MAX) begin
            if (addr == 8'd135)      new_ptr = BYTE_W'(IDX_CA);
            else if (addr == 8'd137) new_ptr = BYTE_W'(IDX_CB);
            else                     new_ptr = cur_ptr;
        end else begin
            new_ptr = addr - OFS;
        end
    end

endmodule

// File: rtl/osc_freeze_check.sv
// Decides whether a frequency-register write breaks the freeze rule.
// Assumes the caller gates the result with "pointer below 6".
module osc_freeze_check
    import osc_cfg_pkg::*;
(
    input  logic [BYTE_W-1:0] ptr,
    input  logic [5:0]        r1_low,
    input  logic              frz_m,
    input  logic              frz_dco,
    output logic              violation
);

    logic frac_upd;

    // Classify the write as a fraction update or a divider update.
    always_comb begin
        frac_upd = (ptr > 8'd1) || ((ptr == 8'd1) && (r1_low != 6'd0));
    end

    // Require the freeze bit that matches the class.
    always_comb begin
        violation = frac_upd ? !(frz_m || frz_dco) : !frz_dco;
    end

endmodule

// File: rtl/osc_reg_bank.sv
// Eight-entry register storage: six frequency bytes and two control bytes.
// Handles the self-clearing control bits and the soft reload of the frequency bytes.
// Assumes wr_en is only raised for an index below 8.
module osc_reg_bank
    import osc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic [5:0]        r1_low,
    output logic              frz_m,
    output logic              frz_dco
);

    logic [BYTE_W-1:0] freq_q [NFREQ];
    logic [BYTE_W-1:0] ca_q;
    logic [BYTE_W-1:0] cb_q;
    logic              ca_wr;
    logic              soft_rst;

    assign ca_wr    = wr_en && (wr_idx == BYTE_W'(IDX_CA));
    assign soft_rst = ca_wr && wr_data[CA_SRST];

    // Frequency bytes: hardware or soft reset loads defaults, else direct write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NFREQ; i++) begin
            if (!rst_n || soft_rst)
                freq_q[i] <= freq_rst_val(i);
            else if (wr_en && (wr_idx == BYTE_W'(i)))
                freq_q[i] <= wr_data;
        end
    end

    // Control A: the reset and new-frequency bits never stay set.
    always_ff @(posedge clk) begin
        if (!rst_n)     ca_q <= '0;
        else if (ca_wr) ca_q <= {2'b00, wr_data[5:0]};
    end

    // Control B: direct write; the divider freeze drops on any control A write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       cb_q <= '0;
        else if (wr_en && (wr_idx == BYTE_W'(IDX_CB)))    cb_q <= wr_data;
        else if (ca_wr)                                   cb_q[CB_FRZD] <= 1'b0;
    end

    // Read mux: zero for any pointer outside the register space.
    always_comb begin
        if (rd_idx >= BYTE_W'(NREGS))          rd_data = '0;
        else if (rd_idx == BYTE_W'(IDX_CA))    rd_data = ca_q;
        else if (rd_idx == BYTE_W'(IDX_CB))    rd_data = cb_q;
        else                                   rd_data = freq_q[rd_idx[2:0]];
    end

    assign r1_low  = freq_q[1][5:0];
    assign frz_m   = ca_q[CA_FRZM];
    assign frz_dco = cb_q[CB_FRZD];

    assert_ctrl_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ca_wr |=> (!ca_q[CA_SRST] && !ca_q[CA_NEWF] && !cb_q[CB_FRZD]));

    assert_soft_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (freq_q[0] == 8'h40 && freq_q[2] == 8'hBC && freq_q[5] == 8'hB8));

endmodule

// File: rtl/osc_cfg_regs.sv
// Top of the oscillator configuration register interface.
// Tracks the transfer phase and the register pointer, routes bytes to the
// bank, flags freeze violations and returns read data.
// Assumes that at most one byte-level event of each kind arrives per cycle.
module osc_cfg_regs
    import osc_cfg_pkg::*;
#(
    parameter int STAB_PPM = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_wr_start,
    input  logic        ev_rd_start,
    input  logic        ev_stop,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rd_req,
    output logic [7:0]  rd_byte,
    output logic        freeze_err,
    output logic [2:0]  phase
);

    phase_e            st_q;
    logic [BYTE_W-1:0] ptr_q;
    logic [BYTE_W-1:0] map_ptr;
    logic [BYTE_W-1:0] bank_rd;
    logic [5:0]        r1_low;
    logic              frz_m;
    logic              frz_dco;
    logic              viol;
    logic              byte_ev;
    logic              addr_ev;
    logic              data_ev;
    logic              freq_ptr;
    logic              bank_wr;

    assign byte_ev  = rx_valid && !ev_stop && !ev_wr_start && !ev_rd_start;
    assign addr_ev  = byte_ev && (st_q == PH_ADDR);
    assign data_ev  = byte_ev && (st_q != PH_ADDR);
    assign freq_ptr = ptr_q < BYTE_W'(NFREQ);
    assign bank_wr  = data_ev && (ptr_q < BYTE_W'(NREGS));

    osc_addr_map #(.STAB_PPM(STAB_PPM)) u_map (
        .addr    (rx_byte),
        .cur_ptr (ptr_q),
        .new_ptr (map_ptr)
    );

    osc_freeze_check u_frz (
        .ptr       (ptr_q),
        .r1_low    (r1_low),
        .frz_m     (frz_m),
        .frz_dco   (frz_dco),
        .violation (viol)
    );

    osc_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr),
        .wr_idx  (ptr_q),
        .wr_data (rx_byte),
        .rd_idx  (ptr_q),
        .rd_data (bank_rd),
        .r1_low  (r1_low),
        .frz_m   (frz_m),
        .frz_dco (frz_dco)
    );

    // Phase machine with fixed event priority.
    always_ff @(posedge clk) begin
        if (!rst_n)           st_q <= PH_IDLE;
        else if (ev_stop)     st_q <= PH_IDLE;
        else if (ev_wr_start) st_q <= PH_ADDR;
        else if (ev_rd_start) st_q <= PH_READ;
        else if (addr_ev)     st_q <= PH_ADONE;
        else if (data_ev)     st_q <= PH_WRITE;
    end

    // Pointer: loaded from an address byte, stepped by frequency writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ptr_q <= '0;
        else if (addr_ev)             ptr_q <= map_ptr;
        else if (data_ev && freq_ptr) ptr_q <= ptr_q + 8'd1;
    end

    // Registered read byte, loaded on request.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_byte <= '0;
        else if (rd_req) rd_byte <= bank_rd;
    end

    // One-cycle freeze error for a frequency write that lacks its freeze bit.
    always_ff @(posedge clk) begin
        if (!rst_n) freeze_err <= 1'b0;
        else        freeze_err <= data_ev && freq_ptr && viol;
    end

    assign phase = st_q;

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (phase == 3'd0));

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(ptr_q));

    assert_ctrl_noinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ev && !freq_ptr) |=> $stable(ptr_q));

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_err |-> $past(rx_valid));

endmodule

// File: tb/sim_osc_cfg_regs.sv
module sim_osc_cfg_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_wr_start = 1'b0;
    logic       ev_rd_start = 1'b0;
    logic       ev_stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rd_req = 1'b0;
    logic [7:0] rd0, rd7;
    logic       err0, err7;
    logic [2:0] ph0, ph7;

    int n_run = 0;
    int n_fail = 0;
    logic last_err;
    logic [7:0] v0, v7;

    always #2 clk = ~clk;

    osc_cfg_regs #(.STAB_PPM(50)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start),
        .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req),
        .rd_byte(rd0), .freeze_err(err0), .phase(ph0));

    osc_cfg_regs #(.STAB_PPM(7)) u7 (
        .clk(clk), .rst_n(rst_n), .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start),
        .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req),
        .rd_byte(rd7), .freeze_err(err7), .phase(ph7));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_start();
        ev_wr_start = 1'b1; tick(); ev_wr_start = 1'b0;
    endtask

    task automatic rd_start();
        ev_rd_start = 1'b1; tick(); ev_rd_start = 1'b0;
    endtask

    task automatic stop();
        ev_stop = 1'b1; tick(); ev_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b; tick(); rx_valid = 1'b0;
        last_err = err0;
    endtask

    task automatic rd();
        rd_req = 1'b1; tick(); rd_req = 1'b0;
        v0 = rd0; v7 = rd7;
    endtask

    task automatic read_at(input logic [7:0] a);
        wr_start(); send(a); stop(); rd_start(); rd(); stop();
    endtask

    task automatic write_at(input logic [7:0] a, input logic [7:0] b);
        wr_start(); send(a); send(b); stop();
    endtask

    function automatic logic [7:0] map_ptr(input logic [7:0] a, input logic [7:0] cur,
                                           input logic [7:0] ofs);
        if (a > 8'd18) return (a == 8'd135) ? 8'd6 : (a == 8'd137) ? 8'd7 : cur;
        return a - ofs;
    endfunction

    logic [7:0] model [8];

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] p50, p7, e0, e7;
        repeat (3) tick();
        rst_n = 1'b1;
        // R7 reset state
        chk("R7 phase", {5'd0, ph0}, 8'd0);
        chk("R7 err", {7'd0, err0}, 8'd0);
        rd_start(); rd(); stop();
        chk("R7 idx0 u0", v0, 8'h40);
        chk("R7 idx0 u7", v7, 8'h40);
        read_at(8);  chk("R7 idx1", v0, 8'hC2);
        read_at(9);  chk("R7 idx2", v0, 8'hBC);
        read_at(10); chk("R7 idx3", v0, 8'h01);
        read_at(11); chk("R7 idx4", v0, 8'h1E);
        read_at(12); chk("R7 idx5", v0, 8'hB8);
        read_at(135); chk("R7 ctrlA", v0, 8'h00);
        read_at(137); chk("R7 ctrlB", v0, 8'h00);

        // R1 phase sequence
        wr_start();  chk("R1 addressing", {5'd0, ph0}, 8'd1);
        send(135);   chk("R1 addr done", {5'd0, ph0}, 8'd2);
        send(8'h25); chk("R1 writing", {5'd0, ph0}, 8'd3);
        rd_start();  chk("R1 reading", {5'd0, ph0}, 8'd4);
        stop();      chk("R1 idle", {5'd0, ph0}, 8'd0);
        // R1 priority: byte with end-of-transfer is dropped
        wr_start(); send(137);
        ev_stop = 1'b1; rx_valid = 1'b1; rx_byte = 8'hFF; tick();
        ev_stop = 1'b0; rx_valid = 1'b0;
        chk("R1 stop wins", {5'd0, ph0}, 8'd0);
        rd_start(); rd(); stop();
        chk("R1 dropped byte", v0, 8'h00);
        write_at(137, 8'h5A);

        // R2 R3 address sweep on both grades
        model = '{8'h40, 8'hC2, 8'hBC, 8'h01, 8'h1E, 8'hB8, 8'h25, 8'h5A};
        p50 = 8'd7; p7 = 8'd7;
        for (int a = 0; a < 256; a++) begin
            p50 = map_ptr(8'(a), p50, 8'd7);
            p7  = map_ptr(8'(a), p7, 8'd13);
            e0 = (p50 < 8) ? model[p50[2:0]] : 8'h00;
            e7 = (p7 < 8)  ? model[p7[2:0]]  : 8'h00;
            read_at(8'(a));
            chk((a > 18) ? "R2 map 50ppm" : "R3 map 50ppm", v0, e0);
            chk((a > 18) ? "R2 map 7ppm" : "R3 map 7ppm", v7, e7);
        end

        // R4 auto-increment across all frequency registers, then into control A
        wr_start(); send(7);
        for (int i = 0; i < 6; i++) begin
            send(8'(8'h11 * (i + 1)));
            chk("R10 no err with freeze", {7'd0, last_err}, 8'd0);
        end
        send(8'h77); stop();
        for (int i = 0; i < 6; i++) begin
            read_at(8'(7 + i));
            chk("R4 stored", v0, 8'(8'h11 * (i + 1)));
        end
        read_at(135); chk("R8 newfreq cleared", v0, 8'h37);
        read_at(137); chk("R8 dco cleared", v0, 8'h4A);

        // R5 control writes do not step the pointer
        wr_start(); send(137); send(8'h01); send(8'h10); stop();
        rd_start(); rd(); stop();
        chk("R5 no increment", v0, 8'h10);

        // R9 R10 freeze matrix
        write_at(135, 8'h00);
        read_at(137); chk("R8 dco cleared again", v0, 8'h00);
        wr_start(); send(9); send(8'hA5);
        chk("R10 err pulse", {7'd0, last_err}, 8'd1);
        tick();
        chk("R10 pulse width", {7'd0, err0}, 8'd0);
        stop();
        read_at(9); chk("R10 stored anyway", v0, 8'hA5);
        wr_start(); send(7); send(8'h99); stop();
        chk("R9 divider no freeze", {7'd0, last_err}, 8'd1);
        write_at(135, 8'h20);
        wr_start(); send(10); send(8'h5C); stop();
        chk("R9 fraction freeze-M", {7'd0, last_err}, 8'd0);
        wr_start(); send(7); send(8'h98); stop();
        chk("R9 divider freeze-M only", {7'd0, last_err}, 8'd1);
        wr_start(); send(8); send(8'h40); stop();
        chk("R9 idx1 fraction class", {7'd0, last_err}, 8'd0);
        wr_start(); send(8); send(8'hC3); stop();
        chk("R9 idx1 divider class", {7'd0, last_err}, 8'd1);
        write_at(137, 8'h10);
        wr_start(); send(7); send(8'h97); stop();
        chk("R9 divider freeze-DCO", {7'd0, last_err}, 8'd0);

        // R8 soft reset
        write_at(135, 8'hA0);
        model = '{8'h40, 8'hC2, 8'hBC, 8'h01, 8'h1E, 8'hB8, 8'h20, 8'h00};
        for (int i = 0; i < 6; i++) begin
            read_at(8'(7 + i));
            chk("R8 soft reload", v0, model[i]);
        end
        read_at(135); chk("R8 ctrlA after reload", v0, 8'h20);
        read_at(137); chk("R8 ctrlB after reload", v0, 8'h00);

        // R4 R6 out-of-range pointer
        wr_start(); send(0); send(8'hEE); stop();
        chk("R4 ignored no err", {7'd0, last_err}, 8'd0);
        rd_start(); rd(); stop();
        chk("R6 out of range", v0, 8'h00);
        read_at(7); chk("R4 ignored write", v0, 8'h40);

        // R6 reads do not advance
        read_at(9);
        rd_start(); rd(); chk("R6 first read", v0, 8'hBC);
        rd(); chk("R6 second read", v0, 8'hBC);
        stop();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule